// File: doc/BRIEF.md
# Polarity-Correcting GPIO Bank with Shared Blink

This block is a bank of general-purpose pins. Software reaches it through a small register port with one address, a write strobe, write data and combinational read data. Each pin owns one bit in each of four writable registers. The direction register selects whether the pin drives its pad. The level register sets the static value that the pin drives. The polarity register chooses whether the input is inverted before software sees it. The blink register swaps the static drive for a shared square wave.

Pad inputs cross into the clock domain through a two-stage synchronizer. They are then XORed with the polarity bits, and the result is offered as a read-only input register. A free-running prescaler toggles one blink phase that all pins share. An output pin with its blink bit set drives that phase ORed with its level bit. Software changes one pin by reading the register, changing that pin's bit and writing the whole word back.

Top module: `gpio_pol_blink_bank`

## Requirements
- R1: After reset, `pad_oe` and `pad_out` are all 0, the direction register (address 0) reads all ones, and the level (1), polarity (2) and blink (3) registers read 0.
- R2: A direction bit of 1 makes the pin an input (`pad_oe` bit 0); a direction bit of 0 sets the pin's `pad_oe` bit to 1. This takes effect the cycle after the write.
- R3: Registers at addresses 0 to 3 read back the last full word written to them.
- R4: Address 4 reads the pad input synchronized through two clock edges and then XORed with the polarity register. A pad change is not yet visible after one rising edge; it is visible after two.
- R5: A polarity bit of 0 passes its pad bit unchanged; a polarity bit of 1 inverts it.
- R6: A write changes only the addressed register. A write to address 4 changes no register.
- R7: A pin whose blink bit is 0 drives its level bit on `pad_out`.
- R8: An output pin whose blink bit is 1 drives the blink phase ORed with its level bit. With level 0 the pad toggles; with level 1 it stays at 1.
- R9: The blink phase toggles once every `BLINK_DIV` clock cycles.
- R10: Addresses 5 to 7 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register address for both read and write |
| wr_en | input | 1 | Write strobe, taken on the rising clock edge |
| wr_data | input | NPINS | Full-word write data |
| rd_data | output | NPINS | Combinational read data for `addr` |
| pad_in | input | NPINS | Raw pad levels, asynchronous |
| pad_oe | output | NPINS | Per-pin driver enable |
| pad_out | output | NPINS | Per-pin drive value |

## Verification
The input-path property assumes `pad_in` is held for at least three rising edges after reset before the data-in value is compared. The stimulus changes `pad_in` only between long quiet stretches. The direction properties assume that `wr_data` and `addr` are valid whenever `wr_en` is high. The bench drives these signals on the falling edge, so they are stable at every rising edge. The blink-period property needs no input condition. The bench still measures the pad waveform across several phases with blink enabled on a level-0 pin.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_DIR = 3'd0,
      RA_LVL = 3'd1,
      RA_POL = 3'd2,
      RA_BLK = 3'd3,
      RA_DIN = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NPINS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NPINS-1:0]  wr_data,
   output logic [NPINS-1:0]  dir_q,
   output logic [NPINS-1:0]  lvl_q,
   output logic [NPINS-1:0]  pol_q,
   output logic [NPINS-1:0]  blk_q
);
   localparam int unsigned NREGS = 4;

   logic [NPINS-1:0] regs_q [NREGS];

   genvar gi;
   generate
      for (gi = 0; gi < NREGS; gi++) begin : g_reg
         localparam logic [NPINS-1:0] RST_VAL = (gi == int'(RA_DIR)) ? '1 : '0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs_q[gi] <= RST_VAL;
            else if (wr_en && (addr == ADDR_W'(gi)))
               regs_q[gi] <= wr_data;
         end
      end
   endgenerate

   assign dir_q = regs_q[int'(RA_DIR)];
   assign lvl_q = regs_q[int'(RA_LVL)];
   assign pol_q = regs_q[int'(RA_POL)];
   assign blk_q = regs_q[int'(RA_BLK)];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   genvar si;
   generate
      for (si = 0; si < STAGES; si++) begin : g_stage
         if (si == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[si] <= '0;
               else        stg[si] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[si] <= '0;
               else        stg[si] <= stg[si-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_blink_div.sv
module gpio_blink_div #(
   parameter int unsigned BLINK_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase
);
   localparam int unsigned CNT_W = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
   localparam logic [CNT_W-1:0] TERM = CNT_W'(BLINK_DIV - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         phase <= 1'b0;
      end else if (cnt_q == TERM) begin
         cnt_q <= '0;
         phase <= ~phase;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/gpio_pol_blink_bank.sv
module gpio_pol_blink_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned BLINK_DIV   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [NPINS-1:0]  wr_data,
   output logic [NPINS-1:0]  rd_data,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_out
);
   generate
      if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
         $error("NPINS must be 1..32");
      end
      if (BLINK_DIV < 2) begin : g_bad_div
         $error("BLINK_DIV must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NPINS-1:0] dir_q, lvl_q, pol_q, blk_q;
   logic [NPINS-1:0] pad_sync, din_val;
   logic             blink_phase;

   gpio_bank_regs #(.NPINS(NPINS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .dir_q   (dir_q),
      .lvl_q   (lvl_q),
      .pol_q   (pol_q),
      .blk_q   (blk_q)
   );

   gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   gpio_blink_div #(.BLINK_DIV(BLINK_DIV)) u_blink (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (blink_phase)
   );

   assign din_val = pad_sync ^ pol_q;

   genvar pi;
   generate
      for (pi = 0; pi < NPINS; pi++) begin : g_pin
         assign pad_oe[pi]  = ~dir_q[pi];
         assign pad_out[pi] = lvl_q[pi] | (blk_q[pi] & ~dir_q[pi] & blink_phase);
      end
   endgenerate

   always_comb begin
      unique case (addr)
         RA_DIR:  rd_data = dir_q;
         RA_LVL:  rd_data = lvl_q;
         RA_POL:  rd_data = pol_q;
         RA_BLK:  rd_data = blk_q;
         RA_DIN:  rd_data = din_val;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NPINS     = 32,
   parameter int unsigned BLINK_DIV = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [NPINS-1:0]  wr_data,
   input logic [NPINS-1:0]  rd_data,
   input logic [NPINS-1:0]  pad_in,
   input logic [NPINS-1:0]  pad_oe,
   input logic [NPINS-1:0]  pol_q,
   input logic              blink_phase
);
   localparam int unsigned GAP_W = $clog2(BLINK_DIV + 2) + 1;

   logic [1:0]       since_rst;
   logic [GAP_W-1:0] gap;
   logic             phase_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= '0;
         gap       <= '0;
         phase_d   <= 1'b0;
      end else begin
         if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
         phase_d <= blink_phase;
         if (blink_phase != phase_d) gap <= GAP_W'(1);
         else                        gap <= gap + 1'b1;
      end
   end

   AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RA_DIR) |=> (pad_oe == ~$past(wr_data))); // R2

   AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == RA_DIR) |=> $stable(pad_oe)); // R6

   AST_DIN_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && addr == RA_DIN && pad_in == $past(pad_in)
       && $past(pad_in) == $past(pad_in, 2))
      |-> (rd_data == (pad_in ^ pol_q))); // R4

   AST_BLINK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (blink_phase != phase_d) |-> (gap == GAP_W'(BLINK_DIV))); // R9
endmodule

bind gpio_pol_blink_bank gpio_bank_chk #(.NPINS(NPINS), .BLINK_DIV(BLINK_DIV)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr        (addr),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .rd_data     (rd_data),
   .pad_in      (pad_in),
   .pad_oe      (pad_oe),
   .pol_q       (pol_q),
   .blink_phase (blink_phase)
);

// File: tb/test_gpio_pol_blink_bank.sv
module test_gpio_pol_blink_bank;
   localparam int unsigned N   = 32;
   localparam int unsigned DIV = 8;
   localparam int unsigned NV  = 6;
   localparam logic [66:0] VEC [NV] = '{
      {3'd0, 32'hFFFF_0000, 32'hFFFF_0000},
      {3'd1, 32'h0000_00A5, 32'h0000_00A5},
      {3'd2, 32'h1234_5678, 32'h1234_5678},
      {3'd3, 32'h0000_0000, 32'h0000_0000},
      {3'd7, 32'hDEAD_BEEF, 32'h0000_0000},
      {3'd0, 32'hFFFF_FFF0, 32'hFFFF_FFF0}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   addr = '0;
   logic         wr_en = 1'b0;
   logic [N-1:0] wr_data = '0;
   logic [N-1:0] rd_data;
   logic [N-1:0] pad_in = '0;
   logic [N-1:0] pad_oe;
   logic [N-1:0] pad_out;

   int checks = 0;
   int fails  = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   gpio_pol_blink_bank #(.NPINS(N), .BLINK_DIV(DIV)) i_gpio_pol_blink_bank (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
      @(negedge clk);
      addr = a;
      #1 v = rd_data;
   endtask

   task automatic finish_up;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         finish_up();
      end
   end

   initial begin
      logic [N-1:0] v;
      logic prev;
      int gap, toggles;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 pad_oe", pad_oe, '0);
      chk("R1 pad_out", pad_out, '0);
      rd(3'd0, v); chk("R1 dir", v, '1);
      rd(3'd1, v); chk("R1 lvl", v, '0);
      rd(3'd2, v); chk("R1 pol", v, '0);
      rd(3'd3, v); chk("R1 blk", v, '0);

      // Table walk: R3 readback, R10 unused address
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][66:64], VEC[i][63:32]);
         rd(VEC[i][66:64], v);
         chk("R3/R10 table", v, VEC[i][31:0]);
      end
      rd(3'd1, v); chk("R6 lvl kept", v, 32'h0000_00A5);
      rd(3'd2, v); chk("R6 pol kept", v, 32'h1234_5678);
      chk("R2 pad_oe", pad_oe, 32'h0000_000F);
      chk("R7 pad_out static", pad_out, 32'h0000_00A5);

      // R4 / R5 polarity and sync latency
      wr(3'd2, 32'h0000_00FF);
      rd(3'd4, v); chk("R5 din idle", v, 32'h0000_00FF);
      @(negedge clk); addr = 3'd4; pad_in = 32'h0F0F_0F0F;
      @(negedge clk); #1 chk("R4 after one edge", rd_data, 32'h0000_00FF);
      @(negedge clk); #1 chk("R4 after two edges", rd_data, 32'h0F0F_0FF0);

      // R6 write to data-in ignored
      wr(3'd4, 32'hFFFF_FFFF);
      rd(3'd4, v); chk("R6 din write ignored", v, 32'h0F0F_0FF0);
      rd(3'd2, v); chk("R6 pol after din write", v, 32'h0000_00FF);
      rd(3'd0, v); chk("R6 dir after din write", v, 32'hFFFF_FFF0);

      // R8 / R9 blink
      wr(3'd1, 32'h0000_0002);
      wr(3'd3, 32'h0000_0003);
      wr(3'd0, 32'hFFFF_FFF8);
      @(negedge clk);
      prev = pad_out[0]; gap = 0; toggles = 0;
      for (int c = 0; c < 5 * DIV; c++) begin
         @(negedge clk);
         gap++;
         if (pad_out[1] !== 1'b1) chk("R8 level-one blink pin", {31'd0, pad_out[1]}, 32'd1);
         if (pad_out[2] !== 1'b0) chk("R7 non-blink pin", {31'd0, pad_out[2]}, 32'd0);
         if (pad_out[0] !== prev) begin
            if (toggles > 0) chk("R9 blink period", 32'(gap), 32'(DIV));
            toggles++; gap = 0; prev = pad_out[0];
         end
      end
      chk("R8 blink toggles", 32'(toggles >= 4), 32'd1);
      chk("R7 pin2 low", {31'd0, pad_out[2]}, 32'd0);

      done = 1'b1;
      finish_up();
   end
endmodule